// File: doc/BRIEF.md
# Power Button Sleep Controller

This block turns an active-low power button into power-state actions. It first synchronises and filters the raw button for a programmable number of clock ticks. A clean falling edge then counts as one press. What the press does depends on the platform power state supplied by the power controller:

- In the working state a press raises a one-cycle SMI or SCI request, chosen by three enable bits.
- In a sleep state a press raises a one-cycle wake request.
- In mechanical-off the press is ignored entirely.

A separate hold timer runs while the filtered button stays down in the working state or in the S3 and S4 sleep states. When it expires, it issues a forced soft-off request that needs no software. A sticky status bit records each recognised press until software clears it. The filter and hold durations are parameters in clock ticks, so a simulation can shorten them.

Top module: `pwrbtn_ctrl`

## Requirements
- R1: A press is recognised only after the synchronised button has stayed low for DEB_TICKS consecutive clock ticks. A low pulse shorter than that produces no output and does not set the status bit.
- R2: The action of a press is issued as soon as the filter accepts the press, while the button is still held. It does not wait for the release.
- R3: With pstate_i = 3'd0 (working), a recognised press gives a one-cycle sci_o pulse when sci_en_i and btn_en_i are both 1. It gives a one-cycle smi_o pulse when sci_en_i is 0 and gsmi_en_i is 1. Otherwise it gives no pulse, and smi_o and sci_o are never high together.
- R4: With pstate_i equal to 3'd3, 3'd4 or 3'd5 (S3, S4, S5), a recognised press gives a one-cycle wake_o pulse and no SMI or SCI pulse.
- R5: With pstate_i = 3'd7 (mechanical-off), the button is neither filtered nor remembered. No output pulses, the status bit is not set, and the hold timer does not run.
- R6: When the filtered button stays pressed for HOLD_TICKS ticks while pstate_i is 3'd0, 3'd3 or 3'd4, force_off_o pulses for one cycle. In S5 the hold timer does not run.
- R7: While stretch_i is 1 (soft-off signal held for its minimum width), a press in a sleep state gives no wake_o pulse.
- R8: sts_o is set by every recognised press and stays set until sts_clr_i is 1 for a cycle. A press in the same cycle as the clear wins.
- R9: After force_off_o has pulsed, it does not pulse again until the button has been released and pressed again, however long it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| btn_ni | input | 1 | Raw active-low power button |
| pstate_i | input | 3 | Power state: 0 working, 3 S3, 4 S4, 5 S5, 7 mechanical-off |
| sci_en_i | input | 1 | Route presses to SCI |
| btn_en_i | input | 1 | Power button event enable |
| gsmi_en_i | input | 1 | Global SMI enable |
| stretch_i | input | 1 | Soft-off signal in minimum-width stretch |
| sts_clr_i | input | 1 | Write-one-to-clear strobe for the status bit |
| smi_o | output | 1 | One-cycle SMI request |
| sci_o | output | 1 | One-cycle SCI request |
| wake_o | output | 1 | One-cycle wake request |
| force_off_o | output | 1 | One-cycle unconditional soft-off request |
| sts_o | output | 1 | Sticky power button status |

## Verification
A filter counter that fails to restart on a bounce shows up as an extra press within DEB_TICKS ticks of the glitch, as a spurious SCI, SMI or wake pulse. A bad latch on the hold override shows up at HOLD_TICKS after the press, either as a missing force_off_o or as a second one one tick later. Wrong state decoding is visible at the press edge itself: the wrong pulse type appears, or a pulse appears in mechanical-off. A status bit that misses a set or a clear is visible on the next sample after the press or the clear strobe.

// File: rtl/pwrbtn_ctrl.sv
module pwrbtn_ctrl #(
  parameter int unsigned DEB_TICKS  = 2_000_000,
  parameter int unsigned HOLD_TICKS = 500_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       btn_ni,
  input  logic [2:0] pstate_i,
  input  logic       sci_en_i,
  input  logic       btn_en_i,
  input  logic       gsmi_en_i,
  input  logic       stretch_i,
  input  logic       sts_clr_i,
  output logic       smi_o,
  output logic       sci_o,
  output logic       wake_o,
  output logic       force_off_o,
  output logic       sts_o
);
  localparam int DW = $clog2(DEB_TICKS + 1);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [DW-1:0] DEB_LAST  = DW'(DEB_TICKS - 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);
  localparam logic [2:0] ST_WORK = 3'd0;
  localparam logic [2:0] ST_S3   = 3'd3;
  localparam logic [2:0] ST_S4   = 3'd4;
  localparam logic [2:0] ST_S5   = 3'd5;
  localparam logic [2:0] ST_OFF  = 3'd7;

  logic [1:0]    sync_q;
  logic          deb_q, fired_q;
  logic [DW-1:0] deb_cnt_q;
  logic [HW-1:0] hold_cnt_q;
  logic smi_q, sci_q, wake_q, off_q, sts_q;

  wire btn_low  = ~sync_q[1];
  wire mech_off = (pstate_i == ST_OFF);
  wire working  = (pstate_i == ST_WORK);
  wire sleeping = (pstate_i == ST_S3) || (pstate_i == ST_S4) || (pstate_i == ST_S5);
  wire hold_ok  = working || (pstate_i == ST_S3) || (pstate_i == ST_S4);
  wire differs  = btn_low != deb_q;
  wire press    = differs && (deb_cnt_q == DEB_LAST) && btn_low && !mech_off;
  wire fire     = deb_q && hold_ok && (hold_cnt_q == HOLD_LAST) && !fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], btn_ni};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deb_q     <= 1'b0;
      deb_cnt_q <= '0;
    end else if (mech_off) begin
      deb_q     <= 1'b0;
      deb_cnt_q <= '0;
    end else if (differs) begin
      if (deb_cnt_q == DEB_LAST) begin
        deb_q     <= btn_low;
        deb_cnt_q <= '0;
      end else begin
        deb_cnt_q <= deb_cnt_q + 1'b1;
      end
    end else begin
      deb_cnt_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_cnt_q <= '0;
      fired_q    <= 1'b0;
    end else begin
      if (!deb_q || !hold_ok)          hold_cnt_q <= '0;
      else if (hold_cnt_q != HOLD_LAST) hold_cnt_q <= hold_cnt_q + 1'b1;
      if (!deb_q)    fired_q <= 1'b0;
      else if (fire) fired_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smi_q  <= 1'b0;
      sci_q  <= 1'b0;
      wake_q <= 1'b0;
      off_q  <= 1'b0;
      sts_q  <= 1'b0;
    end else begin
      sci_q  <= press && working && sci_en_i && btn_en_i;
      smi_q  <= press && working && !sci_en_i && gsmi_en_i;
      wake_q <= press && sleeping && !stretch_i;
      off_q  <= fire;
      if (press)          sts_q <= 1'b1;
      else if (sts_clr_i) sts_q <= 1'b0;
    end
  end

  assign smi_o       = smi_q;
  assign sci_o       = sci_q;
  assign wake_o      = wake_q;
  assign force_off_o = off_q;
  assign sts_o       = sts_q;
endmodule

// File: rtl/pwrbtn_ctrl_chk.sv
module pwrbtn_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] pstate_i,
  input logic       stretch_i,
  input logic       smi_o,
  input logic       sci_o,
  input logic       wake_o,
  input logic       force_off_o,
  input logic       sts_o
);
  p_one_irq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(smi_o && sci_o));

  p_irq_state_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smi_o || sci_o) |-> ($past(pstate_i) == 3'd0));

  p_wake_state_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> ($past(pstate_i) inside {3'd3, 3'd4, 3'd5}));

  p_g3_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pstate_i) == 3'd7) |-> !(smi_o || sci_o || wake_o || force_off_o));

  p_wake_stretch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> !$past(stretch_i));

  p_sts_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smi_o || sci_o || wake_o) |-> sts_o);

  p_off_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_o |=> !force_off_o);
endmodule

bind pwrbtn_ctrl pwrbtn_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pstate_i(pstate_i), .stretch_i(stretch_i),
  .smi_o(smi_o), .sci_o(sci_o), .wake_o(wake_o), .force_off_o(force_off_o),
  .sts_o(sts_o)
);

// File: tb/pwrbtn_ctrl_tb.sv
module pwrbtn_ctrl_tb;
  localparam int DEB  = 8;
  localparam int HOLD = 64;
  localparam int EV_SMI = 1, EV_SCI = 2, EV_WAKE = 3, EV_OFF = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic btn_n = 1'b1, sci_en = 1'b0, btn_en = 1'b0, gsmi_en = 1'b0, stretch = 1'b0, sts_clr = 1'b0;
  logic [2:0] pstate = 3'd0;
  logic smi, sci, wake, foff, sts;
  int checks = 0, fails = 0;
  int exp_q[$];
  int act_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  pwrbtn_ctrl #(.DEB_TICKS(DEB), .HOLD_TICKS(HOLD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .btn_ni(btn_n), .pstate_i(pstate),
    .sci_en_i(sci_en), .btn_en_i(btn_en), .gsmi_en_i(gsmi_en),
    .stretch_i(stretch), .sts_clr_i(sts_clr),
    .smi_o(smi), .sci_o(sci), .wake_o(wake), .force_off_o(foff), .sts_o(sts));

  always @(negedge clk) if (rst_n) begin
    if (smi)  act_q.push_back(EV_SMI);
    if (sci)  act_q.push_back(EV_SCI);
    if (wake) act_q.push_back(EV_WAKE);
    if (foff) act_q.push_back(EV_OFF);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_ev(input int ev);
    exp_q.push_back(ev);
  endtask

  task automatic compare(input string req);
    chk(act_q.size() == exp_q.size(), req, act_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < act_q.size(); i++)
      chk(act_q[i] == exp_q[i], req, act_q[i], exp_q[i]);
    act_q.delete();
    exp_q.delete();
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press_for(input int n);
    btn_n = 1'b0;
    cycles(n);
    btn_n = 1'b1;
    cycles(2 * DEB + 10);
  endtask

  task automatic clear_sts;
    sts_clr = 1'b1;
    cycles(1);
    sts_clr = 1'b0;
    cycles(1);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    chk({smi, sci, wake, foff, sts} == 5'b0, "reset", {smi, sci, wake, foff, sts}, 0);

    // R1: short glitch in working state ignored
    sci_en = 1'b1; btn_en = 1'b1; gsmi_en = 1'b1;
    press_for(DEB - 3);
    compare("R1 glitch");
    chk(sts == 1'b0, "R1 sts after glitch", sts, 0);

    // R2 R3: SCI path, issued before release
    expect_ev(EV_SCI);
    btn_n = 1'b0;
    cycles(DEB + 6);
    compare("R2 before release");
    chk(btn_n == 1'b0, "R2 still held", btn_n, 0);
    btn_n = 1'b1;
    cycles(2 * DEB + 10);
    compare("R3 sci no extra");
    chk(sts == 1'b1, "R8 sts set", sts, 1);
    clear_sts();
    chk(sts == 1'b0, "R8 sts cleared", sts, 0);

    // R3: SMI path
    sci_en = 1'b0; gsmi_en = 1'b1;
    expect_ev(EV_SMI);
    press_for(DEB + 6);
    compare("R3 smi");

    // R3: no interrupt cases
    sci_en = 1'b1; btn_en = 1'b0;
    press_for(DEB + 6);
    sci_en = 1'b0; gsmi_en = 1'b0;
    press_for(DEB + 6);
    compare("R3 none");
    chk(sts == 1'b1, "R8 sts on silent press", sts, 1);
    clear_sts();

    // R4: wake from each sleep state
    sci_en = 1'b1; btn_en = 1'b1; gsmi_en = 1'b1;
    for (int s = 3; s <= 5; s++) begin
      pstate = 3'(s);
      expect_ev(EV_WAKE);
      press_for(DEB + 6);
    end
    compare("R4 wake");

    // R7: stretch blocks wake
    clear_sts();
    pstate = 3'd5; stretch = 1'b1;
    press_for(DEB + 6);
    stretch = 1'b0;
    compare("R7 stretch");
    chk(sts == 1'b1, "R8 sts during stretch", sts, 1);

    // R5: mechanical-off ignores everything
    clear_sts();
    pstate = 3'd7;
    press_for(DEB + 2 * HOLD);
    compare("R5 g3");
    chk(sts == 1'b0, "R5 sts in g3", sts, 0);

    // R6 R9: hold override in S4, single pulse
    pstate = 3'd4;
    expect_ev(EV_WAKE);
    expect_ev(EV_OFF);
    press_for(DEB + 3 * HOLD);
    compare("R9 hold s4");

    // R6: hold override in working state
    pstate = 3'd0;
    expect_ev(EV_SCI);
    expect_ev(EV_OFF);
    press_for(DEB + HOLD + 10);
    compare("R6 hold s0");

    // R6: no hold override in S5
    pstate = 3'd5;
    expect_ev(EV_WAKE);
    press_for(DEB + 3 * HOLD);
    compare("R6 hold s5");

    // R9: new press re-arms override
    pstate = 3'd3;
    expect_ev(EV_WAKE);
    expect_ev(EV_OFF);
    press_for(DEB + HOLD + 10);
    compare("R9 rearm");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule